// File: doc/BRIEF.md
# Quadrature Position Decoder with Read-Clear

This block turns two phase-shifted pulse trains, A and B, into a signed position count. Every legal transition of either input moves the count one step. The direction depends on which input leads. When A changes before B, the count rises. When B changes before A, the count falls. Both inputs pass through a two-stage synchronizer into the system clock domain before they are decoded.

A configuration input selects the role of the input pair. In decoder mode the pair feeds the position count. In dual-counter mode each input counts its own rising edges in a separate counter. Any change of this setting clears the position, both counters and the error flag.

A read strobe captures the position into an output register, and the block pulses a valid flag. A second setting, clear-on-read, zeroes the position right after the captured value leaves. If a count step arrives in the same cycle as a clearing read, that step is not lost: it becomes the first step of the new count.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset the captured position, both edge counters, the valid flag and the error flag are all zero, and a read returns 0.
- R2: In decoder mode, with {A,B} written as a two-bit code and A as the high bit, the sequence 00, 10, 11, 01, 00 (A leading) raises the position by exactly 1 on each transition. The change becomes visible on the third rising clock edge after the input changes.
- R3: The reverse sequence 00, 01, 11, 10, 00 (B leading) lowers the position by 1 on each transition, and the position goes below zero.
- R4: A transition where A and B change together leaves the position unchanged and sets the error flag. The flag then stays set until the next mode change or reset.
- R5: The position is a POS_W-bit two's-complement value (32 by default). It holds at the largest positive value and at the most negative value rather than wrapping.
- R6: The rising clock edge that samples the read strobe high loads the current position into the read output and raises the valid flag for exactly that one cycle. The read output then holds its value until the next read.
- R7: With clear-on-read set, the position is zero after a read. With clear-on-read low, a read leaves the position unchanged.
- R8: When a count step and a clearing read land on the same clock edge, the read returns the value without that step, and the position restarts at +1 or -1 in the step's direction.
- R9: In dual-counter mode each rising edge of A adds 1 to the A counter and each rising edge of B adds 1 to the B counter. Each counter wraps modulo 2^CNT_W (CNT_W is 16 by default), and the position stays at zero.
- R10: Any change of the mode input clears the position, both edge counters and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDualMode | input | 1 | 1 selects two edge counters, 0 selects the quadrature decoder |
| cfgClearOnRead | input | 1 | 1 clears the position after each read |
| inA | input | 1 | Asynchronous input A |
| inB | input | 1 | Asynchronous input B |
| rdStrobe | input | 1 | Read request, one cycle per read |
| rdPosition | output | POS_W | Position captured by the last read (two's complement) |
| rdValid | output | 1 | High for one cycle after a read captures a value |
| cntA | output | CNT_W | Rising-edge count of A in dual-counter mode |
| cntB | output | CNT_W | Rising-edge count of B in dual-counter mode |
| seqError | output | 1 | Sticky flag for a transition where A and B changed together |

## Verification
The bench aims a count step at the exact edge where a clearing read is sampled. A design that drops that step would restart at zero, and one that folds the step into the returned value would report one count too many. It drives the count to both saturation limits, where a design without the limit checks would wrap to the opposite sign. It also sends transitions where both inputs change together; a design that decodes them would move the position, and one whose flag is not sticky would lose the error after the next good step. Mode changes are made with nonzero counters, a nonzero position and the error flag set, and the dual-counter counts are taken past their wrap point.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

  // Control-to-datapath strobes, all valid for a single cycle
  typedef struct packed {
    logic stepUp;     // one count forward
    logic stepDown;   // one count backward
    logic latch;      // capture position into the read register
    logic clearPos;   // restart position after the capture
    logic modeClear;  // mode setting changed: clear everything
    logic incA;       // rising edge of A in dual-counter mode
    logic incB;       // rising edge of B in dual-counter mode
    logic flagErr;    // both inputs moved at once
  } qpdStrobes_t;

endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/qpd_ctrl.sv
module qpd_ctrl
  import qpd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgDualMode,
  input  logic        cfgClearOnRead,
  input  logic        rdStrobe,
  input  logic [1:0]  curAB,      // {A,B} after synchronization
  output qpdStrobes_t strb,
  output logic        modeQ
);

  logic [1:0] prevAB;
  logic       moved;
  logic       bothMoved;
  logic       forward;
  logic       modeChange;
  logic       decodeOn;
  logic       countOn;

  // Forward order with A leading: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic isForward(input logic [1:0] p, input logic [1:0] c);
    logic [1:0] nxt;
    unique case (p)
      2'b00:   nxt = 2'b10;
      2'b10:   nxt = 2'b11;
      2'b11:   nxt = 2'b01;
      default: nxt = 2'b00;
    endcase
    return c == nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAB <= 2'b00;
      modeQ  <= 1'b0;
    end else begin
      prevAB <= curAB;
      modeQ  <= cfgDualMode;
    end
  end

  always_comb begin
    moved      = curAB != prevAB;
    bothMoved  = &(curAB ^ prevAB);
    forward    = isForward(prevAB, curAB);
    modeChange = cfgDualMode != modeQ;
    decodeOn   = !modeQ && !modeChange;
    countOn    = modeQ && !modeChange;

    strb.stepUp    = decodeOn && moved && !bothMoved && forward;
    strb.stepDown  = decodeOn && moved && !bothMoved && !forward;
    strb.flagErr   = decodeOn && bothMoved;
    strb.latch     = rdStrobe;
    strb.clearPos  = rdStrobe && cfgClearOnRead;
    strb.modeClear = modeChange;
    strb.incA      = countOn && !prevAB[1] && curAB[1];
    strb.incB      = countOn && !prevAB[0] && curAB[0];
  end

endmodule

// File: rtl/qpd_datapath.sv
module qpd_datapath
  import qpd_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qpdStrobes_t       strb,
  output logic [POS_W-1:0]  posValue,
  output logic [POS_W-1:0]  rdPosition,
  output logic              rdValid,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic              seqError
);

  localparam logic [POS_W-1:0] PosMax = {1'b0, {(POS_W-1){1'b1}}};
  localparam logic [POS_W-1:0] PosMin = {1'b1, {(POS_W-1){1'b0}}};
  localparam logic [POS_W-1:0] PosOne = {{(POS_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CntOne = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] posNext;

  // A step that meets a clearing read seeds the fresh count
  always_comb begin
    posNext = posQ;
    if (strb.modeClear)
      posNext = '0;
    else if (strb.clearPos)
      posNext = strb.stepUp ? PosOne : (strb.stepDown ? '1 : '0);
    else if (strb.stepUp && posQ != PosMax)
      posNext = posQ + PosOne;
    else if (strb.stepDown && posQ != PosMin)
      posNext = posQ - PosOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ       <= '0;
      rdPosition <= '0;
      rdValid    <= 1'b0;
      cntA       <= '0;
      cntB       <= '0;
      seqError   <= 1'b0;
    end else begin
      posQ    <= posNext;
      rdValid <= strb.latch;
      if (strb.latch) rdPosition <= posQ;
      if (strb.modeClear) begin
        cntA     <= '0;
        cntB     <= '0;
        seqError <= 1'b0;
      end else begin
        if (strb.incA)    cntA     <= cntA + CntOne;
        if (strb.incB)    cntB     <= cntB + CntOne;
        if (strb.flagErr) seqError <= 1'b1;
      end
    end
  end

  assign posValue = posQ;

endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qpd_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDualMode,
  input  logic             cfgClearOnRead,
  input  logic             inA,
  input  logic             inB,
  input  logic             rdStrobe,
  output logic [POS_W-1:0] rdPosition,
  output logic             rdValid,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic             seqError
);

  logic [1:0]       curAB;
  qpdStrobes_t      strb;
  logic             modeQ;
  logic [POS_W-1:0] posValue;

  qpd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({inA, inB}),
    .dout (curAB)
  );

  qpd_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgDualMode    (cfgDualMode),
    .cfgClearOnRead (cfgClearOnRead),
    .rdStrobe       (rdStrobe),
    .curAB          (curAB),
    .strb           (strb),
    .modeQ          (modeQ)
  );

  qpd_datapath #(.POS_W(POS_W), .CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .posValue   (posValue),
    .rdPosition (rdPosition),
    .rdValid    (rdValid),
    .cntA       (cntA),
    .cntB       (cntB),
    .seqError   (seqError)
  );

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int POS_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgDualMode,
  input logic             rdStrobe,
  input logic             rdValid,
  input logic [POS_W-1:0] rdPosition,
  input logic [CNT_W-1:0] cntA,
  input logic [CNT_W-1:0] cntB,
  input logic             seqError,
  input logic             modeQ,
  input logic [POS_W-1:0] posValue
);

  // R6: the valid flag follows the read strobe by one cycle
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);
  p_valid_only_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !rdValid);

  // R6: the captured value changes only on a read
  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdPosition));

  // R2: without a read or mode change the position moves at most one count
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && cfgDualMode == modeQ) |=>
      (($signed({posValue[POS_W-1], posValue}) -
        $signed({$past(posValue[POS_W-1]), $past(posValue)})) inside {-1, 0, 1}));

  // R4: the error flag is sticky while the mode holds
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqError && cfgDualMode == modeQ) |=> seqError);

  // R9: the position stays zero in dual-counter mode
  p_dual_pos_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> posValue == '0);

  // R10: a mode change clears counters and error flag
  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDualMode != modeQ) |=> (cntA == '0 && cntB == '0 && !seqError && posValue == '0));

endmodule

bind quad_pos_decoder qpd_checker #(.POS_W(POS_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgDualMode (cfgDualMode),
  .rdStrobe    (rdStrobe),
  .rdValid     (rdValid),
  .rdPosition  (rdPosition),
  .cntA        (cntA),
  .cntB        (cntB),
  .seqError    (seqError),
  .modeQ       (modeQ),
  .posValue    (posValue)
);

// File: tb/quad_pos_decoder_tb.sv
`timescale 1ns/1ps
module quad_pos_decoder_tb_top;

  localparam int POS_W = 8;   // small widths make limits and wrap reachable
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgDualMode = 1'b0;
  logic             cfgClearOnRead = 1'b0;
  logic             inA = 1'b0;
  logic             inB = 1'b0;
  logic             rdStrobe = 1'b0;
  logic [POS_W-1:0] rdPosition;
  logic             rdValid;
  logic [CNT_W-1:0] cntA;
  logic [CNT_W-1:0] cntB;
  logic             seqError;

  int checks = 0;
  int errors = 0;
  logic [1:0] ab = 2'b00;

  always #10 clk = ~clk;

  quad_pos_decoder #(.POS_W(POS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgDualMode(cfgDualMode), .cfgClearOnRead(cfgClearOnRead),
    .inA(inA), .inB(inB), .rdStrobe(rdStrobe), .rdPosition(rdPosition),
    .rdValid(rdValid), .cntA(cntA), .cntB(cntB), .seqError(seqError)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyAB(input logic [1:0] v);
    @(negedge clk);
    ab = v; inA = v[1]; inB = v[0];
    settle();
  endtask

  function automatic logic [1:0] nextFwd(input logic [1:0] p);
    case (p)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] nextRev(input logic [1:0] p);
    case (p)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic stepsFwd(input int n);
    for (int i = 0; i < n; i++) applyAB(nextFwd(ab));
  endtask

  task automatic stepsRev(input int n);
    for (int i = 0; i < n; i++) applyAB(nextRev(ab));
  endtask

  task automatic readChk(input string req, input int exp);
    @(negedge clk); rdStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk); rdStrobe = 1'b0;
    chk({req, " valid"}, int'(rdValid), 1);
    chk(req, int'($signed(rdPosition)), exp);
    @(posedge clk);
    @(negedge clk);
    chk("R6 valid one cycle", int'(rdValid), 0);
    chk("R6 read held", int'($signed(rdPosition)), exp);
  endtask

  task automatic t_reset();
    chk("R1 reset rdPosition", int'(rdPosition), 0);
    chk("R1 reset rdValid", int'(rdValid), 0);
    chk("R1 reset cntA", int'(cntA), 0);
    chk("R1 reset cntB", int'(cntB), 0);
    chk("R1 reset seqError", int'(seqError), 0);
    readChk("R1 reset read", 0);
  endtask

  task automatic t_forward();
    // R2: change visible after the third rising edge, not earlier
    @(negedge clk); ab = 2'b10; inA = 1'b1; inB = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdStrobe = 1'b1; @(posedge clk); @(negedge clk); rdStrobe = 1'b0;
    chk("R2 no change before third edge", int'($signed(rdPosition)), 0);
    settle();
    readChk("R2 one forward step", 1);
    stepsFwd(7);
    readChk("R2 forward steps", 8);
    readChk("R7 no clear when disabled", 8);
  endtask

  task automatic t_reverse();
    stepsRev(12);
    readChk("R3 reverse to negative", -4);
  endtask

  task automatic t_invalid();
    applyAB(ab ^ 2'b11);
    readChk("R4 double change ignored", -4);
    chk("R4 error set", int'(seqError), 1);
    stepsFwd(1);
    readChk("R4 good step after error", -3);
    chk("R4 error sticky", int'(seqError), 1);
  endtask

  task automatic t_clear();
    cfgClearOnRead = 1'b1;
    readChk("R7 read before clear", -3);
    readChk("R7 cleared after read", 0);
  endtask

  task automatic t_same_cycle();
    stepsFwd(2);
    // step lands on the edge that samples the clearing read
    @(negedge clk); ab = nextFwd(ab); inA = ab[1]; inB = ab[0];
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdStrobe = 1'b1; @(posedge clk); @(negedge clk); rdStrobe = 1'b0;
    chk("R8 read excludes step", int'($signed(rdPosition)), 2);
    settle();
    readChk("R8 cleared count starts at +1", 1);
    @(negedge clk); ab = nextRev(ab); inA = ab[1]; inB = ab[0];
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdStrobe = 1'b1; @(posedge clk); @(negedge clk); rdStrobe = 1'b0;
    chk("R8 read excludes reverse step", int'($signed(rdPosition)), 0);
    settle();
    readChk("R8 cleared count starts at -1", -1);
    cfgClearOnRead = 1'b0;
  endtask

  task automatic t_saturate();
    stepsFwd(131);
    readChk("R5 hold at maximum", 127);
    stepsRev(260);
    readChk("R5 hold at minimum", -128);
    stepsFwd(1);
    readChk("R5 leave minimum", -127);
  endtask

  task automatic t_modes();
    applyAB(2'b00);
    chk("R4 error still set", int'(seqError), 1);
    @(negedge clk); cfgDualMode = 1'b1;
    settle();
    chk("R10 error cleared", int'(seqError), 0);
    readChk("R10 position cleared", 0);
    for (int i = 0; i < 3; i++) begin applyAB(2'b10); applyAB(2'b00); end
    for (int i = 0; i < 5; i++) begin applyAB(2'b01); applyAB(2'b00); end
    chk("R9 cntA", int'(cntA), 3);
    chk("R9 cntB", int'(cntB), 5);
    readChk("R9 position stays zero", 0);
    for (int i = 0; i < 14; i++) begin applyAB(2'b10); applyAB(2'b00); end
    chk("R9 cntA wraps", int'(cntA), 1);
    @(negedge clk); cfgDualMode = 1'b0;
    settle();
    chk("R10 cntA cleared", int'(cntA), 0);
    chk("R10 cntB cleared", int'(cntB), 0);
    stepsFwd(3);
    readChk("R2 decoding resumes", 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_invalid();
    t_clear();
    t_same_cycle();
    t_saturate();
    t_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule